// File: doc/BRIEF.md
# Field Capture and Replay Sequencer

This block sequences an instant-replay feature inside a video overlay controller. While capture is armed, it keeps one incoming field out of every N and hands each kept field to a circular field store. It does this by pulsing a write enable together with the slot number. The slot number wraps, so the store always holds the most recent kept fields. When the arm control drops, writing stops and the store is frozen.

Once the store is frozen and the playback control is raised, the block walks a read slot index through the stored fields. It starts at the oldest field and wraps back to it after the newest. Each stored field is shown for N times 1, 2, 4 or 8 display fields, so replay runs at the capture rate or slower. The pixel path, the memory interface and the register bus sit outside this block. Here those registers appear as plain level inputs.

Top module: `field_replay_seq`

## Requirements
- R1: While armed, the first field strobe after arming is kept, and after that one strobe in every N. N comes from `capt_code`: 00 gives 4, 01 gives 6, 10 gives 8 and 11 gives 10.
- R2: During replay each stored slot is held for N·M field strobes. M comes from `play_code`: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R3: Capture arms only in a cycle where `save_ctl` is 1 and every bit of `ovl_en` is 0. A high `save_ctl` while any overlay bit is set produces no write.
- R4: Once `save_ctl` is 0, no further write occurs and the stored fields are left unchanged.
- R5: For each kept field, `fld_wr_en` is high for exactly one cycle, the cycle after the strobe. `wr_idx` carries that field's slot in the same cycle.
- R6: Arming empties the store. Write slots then run 0, 1, 2 and so on, and wrap to 0 after slot NUM_SLOTS-1.
- R7: `replay_active` rises one cycle after `play_ctl` is seen at 1, provided capture is not armed and at least one field is stored. `rd_idx` then equals the oldest slot: slot 0 if the store never wrapped, otherwise the slot after the newest.
- R8: `rd_idx` advances by one slot per hold period, and returns to the oldest slot after the newest one has been shown.
- R9: When `play_ctl` is 0 in a cycle, `replay_active` is 0 in the next cycle.
- R10: After reset, every output is 0, the store is empty, and replay cannot start until at least one field has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_start | input | 1 | One-cycle strobe at the start of each incoming field |
| capt_code | input | 2 | Capture keep-ratio code |
| play_code | input | 2 | Replay slow-down code |
| save_ctl | input | 1 | Arm capture (1) / freeze store (0) |
| play_ctl | input | 1 | Replay run (1) / stop (0) |
| ovl_en | input | NUM_WIN | Overlay window enables; all must be 0 to arm |
| fld_wr_en | output | 1 | Field write pulse for the store |
| wr_idx | output | $clog2(NUM_SLOTS) | Slot being written |
| rd_idx | output | $clog2(NUM_SLOTS) | Slot being shown during replay |
| replay_active | output | 1 | Replay is running |

## Verification
A wrong decimation count shows up at the ports within one capture period, as a write pulse missing or too early relative to the strobes. A write pointer that is off by one, or that fails to wrap, shows on `wr_idx` at the very next pulse. Errors in the oldest-slot calculation or in the hold counter show on `rd_idx` in the first cycle of replay, or at the end of the first hold period. The bench sweeps every combination of keep ratio and slow-down, using both a wrapped and an unwrapped store. It computes the expected slot after every strobe.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        KEEP_1_OF_4  = 2'b00,
        KEEP_1_OF_6  = 2'b01,
        KEEP_1_OF_8  = 2'b10,
        KEEP_1_OF_10 = 2'b11
    } keep_code_e;

    typedef enum logic [1:0] {
        SLOW_X1 = 2'b00,
        SLOW_X2 = 2'b01,
        SLOW_X4 = 2'b10,
        SLOW_X8 = 2'b11
    } slow_code_e;

    localparam int PERIOD_W = 4;
    localparam int HOLD_W   = 7;

    typedef struct packed {
        logic armed;
        logic arm_now;
    } arm_state_t;

    function automatic logic [PERIOD_W-1:0] keep_period(keep_code_e c);
        logic [PERIOD_W-1:0] p;
        case (c)
            KEEP_1_OF_4:  p = 4'd4;
            KEEP_1_OF_6:  p = 4'd6;
            KEEP_1_OF_8:  p = 4'd8;
            default:      p = 4'd10;
        endcase
        return p;
    endfunction

    function automatic logic [HOLD_W-1:0] hold_fields(keep_code_e k, slow_code_e s);
        logic [HOLD_W-1:0] base;
        base = {{(HOLD_W-PERIOD_W){1'b0}}, keep_period(k)};
        return base << s;
    endfunction

endpackage

// File: rtl/fr_arm_ctl.sv
module fr_arm_ctl
    import fr_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               save_ctl,
    input  logic [NUM_WIN-1:0] ovl_en,
    output arm_state_t         arm_st
);

    logic armed_q;
    logic arm_now;

    assign arm_now = save_ctl && !armed_q && (ovl_en == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (!save_ctl) begin
            armed_q <= 1'b0;
        end else if (arm_now) begin
            armed_q <= 1'b1;
        end
    end

    assign arm_st.armed   = armed_q;
    assign arm_st.arm_now = arm_now;

    // R3: arming only happens with every overlay window off
    a_r3_arm_needs_dark: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_q) |-> ($past(ovl_en) == '0));

    // R4: a low save control disarms on the next edge
    a_r4_save_low_disarms: assert property (@(posedge clk) disable iff (rst)
        !save_ctl |=> !armed_q);

endmodule

// File: rtl/fr_capture.sv
module fr_capture
    import fr_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_start,
    input  keep_code_e        keep_code,
    input  arm_state_t        arm_st,
    output logic              fld_wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] wr_ptr,
    output logic [CNT_W-1:0]  valid_cnt
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(NUM_SLOTS);

    logic [PERIOD_W-1:0] dec_q;
    logic [PERIOD_W-1:0] period;
    logic                dec_wrap;

    assign period   = keep_period(keep_code);
    assign dec_wrap = (dec_q >= period - PERIOD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            fld_wr_en <= 1'b0;
            wr_slot   <= '0;
            wr_ptr    <= '0;
            valid_cnt <= '0;
            dec_q     <= '0;
        end else begin
            fld_wr_en <= 1'b0;
            if (arm_st.arm_now) begin
                wr_ptr    <= '0;
                valid_cnt <= '0;
                dec_q     <= '0;
            end else if (arm_st.armed) begin
                if (field_start) begin
                    if (dec_q == '0) begin
                        fld_wr_en <= 1'b1;
                        wr_slot   <= wr_ptr;
                        wr_ptr    <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
                        if (valid_cnt != FULL_CNT) begin
                            valid_cnt <= valid_cnt + 1'b1;
                        end
                    end
                    dec_q <= dec_wrap ? '0 : dec_q + 1'b1;
                end
            end else begin
                dec_q <= '0;
            end
        end
    end

    // R5: a write pulse lasts one cycle (keep ratio is at least 4)
    a_r5_wr_single: assert property (@(posedge clk) disable iff (rst)
        fld_wr_en |=> !fld_wr_en);

    // R4: writes come only from an armed cycle
    a_r4_wr_needs_arm: assert property (@(posedge clk) disable iff (rst)
        fld_wr_en |-> $past(arm_st.armed));

    // R6: the fill count never passes the slot count
    a_r6_valid_bound: assert property (@(posedge clk) disable iff (rst)
        valid_cnt <= FULL_CNT);

endmodule

// File: rtl/fr_playback.sv
module fr_playback
    import fr_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              field_start,
    input  keep_code_e        keep_code,
    input  slow_code_e        slow_code,
    input  logic              play_ctl,
    input  arm_state_t        arm_st,
    input  logic [SLOT_W-1:0] wr_ptr,
    input  logic [CNT_W-1:0]  valid_cnt,
    output logic [SLOT_W-1:0] rd_idx,
    output logic              replay_active
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(NUM_SLOTS);

    logic              play_q;
    logic [SLOT_W-1:0] rd_q;
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] hold_len;
    logic [SLOT_W-1:0] oldest;
    logic [SLOT_W-1:0] newest;
    logic              full;
    logic              go;

    assign full     = (valid_cnt == FULL_CNT);
    assign oldest   = full ? wr_ptr : '0;
    assign newest   = full ? ((wr_ptr == '0) ? LAST_SLOT : wr_ptr - 1'b1)
                           : SLOT_W'(valid_cnt - CNT_W'(1));
    assign hold_len = hold_fields(keep_code, slow_code);
    assign go       = play_ctl && !arm_st.armed && !arm_st.arm_now && (valid_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            play_q <= 1'b0;
            rd_q   <= '0;
            hold_q <= '0;
        end else if (!go) begin
            play_q <= 1'b0;
            hold_q <= '0;
        end else if (!play_q) begin
            play_q <= 1'b1;
            rd_q   <= oldest;
            hold_q <= '0;
        end else if (field_start) begin
            if (hold_q >= hold_len - HOLD_W'(1)) begin
                hold_q <= '0;
                rd_q   <= (rd_q == newest) ? oldest
                        : ((rd_q == LAST_SLOT) ? '0 : rd_q + 1'b1);
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    assign rd_idx        = rd_q;
    assign replay_active = play_q;

    // R9: dropping the play control stops replay on the next edge
    a_r9_stop_next: assert property (@(posedge clk) disable iff (rst)
        !play_ctl |=> !play_q);

    // R8: while replaying, the read slot lies inside the filled part
    a_r8_rd_in_store: assert property (@(posedge clk) disable iff (rst)
        play_q |-> (CNT_W'(rd_q) < valid_cnt));

    // R10: replay never runs on an empty store
    a_r10_needs_data: assert property (@(posedge clk) disable iff (rst)
        play_q |-> (valid_cnt != '0));

    // R2: hold counter stays below the hold length
    a_r2_hold_bound: assert property (@(posedge clk) disable iff (rst)
        play_q |-> (hold_q < hold_len));

endmodule

// File: rtl/field_replay_seq.sv
module field_replay_seq
    import fr_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_WIN   = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               field_start,
    input  logic [1:0]         capt_code,
    input  logic [1:0]         play_code,
    input  logic               save_ctl,
    input  logic               play_ctl,
    input  logic [NUM_WIN-1:0] ovl_en,
    output logic               fld_wr_en,
    output logic [SLOT_W-1:0]  wr_idx,
    output logic [SLOT_W-1:0]  rd_idx,
    output logic               replay_active
);

    arm_state_t        arm_st;
    logic [SLOT_W-1:0] wr_ptr;
    logic [CNT_W-1:0]  valid_cnt;
    keep_code_e        keep_code;
    slow_code_e        slow_code;

    assign keep_code = keep_code_e'(capt_code);
    assign slow_code = slow_code_e'(play_code);

    fr_arm_ctl #(.NUM_WIN(NUM_WIN)) arm_i (
        .clk      (clk),
        .rst      (rst),
        .save_ctl (save_ctl),
        .ovl_en   (ovl_en),
        .arm_st   (arm_st)
    );

    fr_capture #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) cap_i (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .keep_code   (keep_code),
        .arm_st      (arm_st),
        .fld_wr_en   (fld_wr_en),
        .wr_slot     (wr_idx),
        .wr_ptr      (wr_ptr),
        .valid_cnt   (valid_cnt)
    );

    fr_playback #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) pb_i (
        .clk           (clk),
        .rst           (rst),
        .field_start   (field_start),
        .keep_code     (keep_code),
        .slow_code     (slow_code),
        .play_ctl      (play_ctl),
        .arm_st        (arm_st),
        .wr_ptr        (wr_ptr),
        .valid_cnt     (valid_cnt),
        .rd_idx        (rd_idx),
        .replay_active (replay_active)
    );

    // R5: the write slot matches the slot the store just advanced past
    a_r5_slot_follows_ptr: assert property (@(posedge clk) disable iff (rst)
        fld_wr_en |-> (wr_idx == ((wr_ptr == '0) ? SLOT_W'(NUM_SLOTS - 1) : wr_ptr - 1'b1)));

endmodule

// File: tb/field_replay_seq_tb_top.sv
module field_replay_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 4;
    localparam int SW         = $clog2(SLOTS);

    logic          clk = 1'b0;
    logic          rst;
    logic          field_start;
    logic [1:0]    capt_code;
    logic [1:0]    play_code;
    logic          save_ctl;
    logic          play_ctl;
    logic [3:0]    ovl_en;
    logic          fld_wr_en;
    logic [SW-1:0] wr_idx;
    logic [SW-1:0] rd_idx;
    logic          replay_active;

    int checks = 0;
    int errors = 0;
    int exp_wr = 0;
    int wr_seen = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    field_replay_seq #(.NUM_SLOTS(SLOTS), .NUM_WIN(4)) dut_i (
        .clk(clk), .rst(rst), .field_start(field_start),
        .capt_code(capt_code), .play_code(play_code),
        .save_ctl(save_ctl), .play_ctl(play_ctl), .ovl_en(ovl_en),
        .fld_wr_en(fld_wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx),
        .replay_active(replay_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic pulse_field();
        @(negedge clk) field_start = 1'b1;
        @(negedge clk) field_start = 1'b0;
        @(negedge clk);
    endtask

    // R5 R6: every write pulse carries the next slot in sequence
    always @(negedge clk) begin
        if (!rst && fld_wr_en) begin
            check(int'(wr_idx) == exp_wr % SLOTS, "R6 write slot", int'(wr_idx), exp_wr % SLOTS);
            exp_wr++;
            wr_seen++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; field_start = 1'b0; capt_code = 2'b00; play_code = 2'b00;
        save_ctl = 1'b0; play_ctl = 1'b0; ovl_en = 4'b0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check(fld_wr_en == 1'b0, "R10 wr_en", int'(fld_wr_en), 0);
        check(replay_active == 1'b0, "R10 active", int'(replay_active), 0);
        check(wr_idx == '0, "R10 wr_idx", int'(wr_idx), 0);
        check(rd_idx == '0, "R10 rd_idx", int'(rd_idx), 0);

        // R10: replay on an empty store never starts
        play_ctl = 1'b1;
        for (int i = 0; i < 3; i++) begin
            pulse_field();
            check(replay_active == 1'b0, "R10 empty store", int'(replay_active), 0);
        end
        play_ctl = 1'b0;
        repeat (2) @(negedge clk);

        // R3: overlay on blocks arming
        ovl_en = 4'b0100;
        save_ctl = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 12; i++) pulse_field();
        check(wr_seen == 0, "R3 no arm with overlay", wr_seen, 0);
        save_ctl = 1'b0;
        @(negedge clk);
        ovl_en = 4'b0000;
        @(negedge clk);

        // R1 R2 R4 R6 R7 R8 R9 sweep
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 4; s++) begin
                int n;
                int nf;
                int writes;
                int valid;
                int oldest;
                int hold;
                n  = 4 + 2 * k;
                nf = (s % 2 == 0) ? 5 * n + 1 : 2 * n + 1;

                capt_code = 2'(k);
                exp_wr = 0;
                wr_seen = 0;
                save_ctl = 1'b1;
                repeat (2) @(negedge clk);
                for (int f = 0; f < nf; f++) pulse_field();
                save_ctl = 1'b0;
                repeat (2) @(negedge clk);
                writes = (nf + n - 1) / n;
                check(wr_seen == writes, "R1 kept field count", wr_seen, writes);

                valid  = (writes < SLOTS) ? writes : SLOTS;
                oldest = (writes > SLOTS) ? writes % SLOTS : 0;
                hold   = n << s;

                play_code = 2'(s);
                play_ctl = 1'b1;
                @(negedge clk);
                check(replay_active == 1'b1, "R7 replay starts", int'(replay_active), 1);
                check(int'(rd_idx) == oldest, "R7 oldest slot", int'(rd_idx), oldest);

                for (int j = 1; j <= (valid + 1) * hold; j++) begin
                    int e;
                    pulse_field();
                    e = (oldest + (j / hold) % valid) % SLOTS;
                    check(int'(rd_idx) == e, "R2 R8 read slot", int'(rd_idx), e);
                end
                check(wr_seen == writes, "R4 store frozen", wr_seen, writes);

                play_ctl = 1'b0;
                @(negedge clk);
                check(replay_active == 1'b0, "R9 stop", int'(replay_active), 0);
                @(negedge clk);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule